// File: doc/BRIEF.md
# GPIO Event Detect and Interrupt Unit

This unit watches every pin of a 54-pin general-purpose I/O controller and records events that software has asked for. There are six kinds of detection, and software enables each one pin by pin:
- a rising or falling edge on the synchronized pin level;
- a rising or falling edge on the raw, unsynchronized pin input;
- a high level or a low level on the synchronized pin.

Any enabled event sets a sticky bit in the status word of the pin's bank. Pins are grouped in banks of 32, so pin `p` lives in bank `p/32` at bit `p%32`.

Each bank drives its own interrupt line. The line stays high while any status bit of that bank is set. Software services an event and then writes a one to the status bit to remove it. A level-type event is raised again on the next clock while its level still holds, so clearing it has no lasting effect until the pin level changes.

The register port is a single word-addressed port. A write strobe, byte address and write data update state on the clock edge. Read data is a combinational function of the address. Pin levels arrive already synchronized on one input and raw on another.

Top module: `gpio_evt_unit`

## Requirements
- R1: After reset every enable word and both status words read 0 and both interrupt lines are low.
- R2: Enable words sit at byte offsets 0x4C (sync rising), 0x58 (sync falling), 0x64 (high level), 0x70 (low level), 0x7C (raw rising) and 0x88 (raw falling), with the bank-1 word at offset +4. They read back what was written. Bits for pins above 53 read 0 (bank-1 word masked to 0x003FFFFF).
- R3: With its sync-rising enable set, a pin whose synchronized level goes from 0 to 1 has its status bit set after the next clock edge.
- R4: With its sync-falling enable set, a pin whose synchronized level goes from 1 to 0 has its status bit set after the next clock edge. A rising edge on that pin sets nothing.
- R5: Setting both the rising and falling enables of one pin records an event on each edge direction.
- R6: While a pin's high-level (or low-level) enable is set and the level holds, its status bit is set again every clock. A clear written during that time leaves the bit set. Once the level goes away, a clear removes it.
- R7: Raw-edge detection follows the raw pin input, whatever the synchronized input does, and is recorded in the same status word.
- R8: The status words sit at 0x40 (bank 0) and 0x44 (bank 1). Writing 1 to a bit clears it and writing 0 leaves it unchanged. Without a clear, a set bit stays set.
- R9: If a new event and a clear of the same bit land in the same cycle, the bit remains set.
- R10: Interrupt line b is high exactly while bank b has any status bit set. Clearing one bank does not affect the other line.
- R11: A pin with none of its enables set never sets its status bit, whatever its inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinSync | input | 54 | Synchronized pin levels |
| pinRaw | input | 54 | Raw pin inputs for raw-edge detection |
| wrEn | input | 1 | Register write strobe |
| regAddr | input | 8 | Register byte address for reads and writes |
| wrData | input | 32 | Register write data |
| rdData | output | 32 | Register read data at regAddr |
| irq | output | 2 | Per-bank interrupt lines |

## Verification
Two situations are hard to reach from the ports. The first is a clear that lands in the same cycle as a fresh event on the same bit. The second is a clear issued while a level condition still holds.

To reach the first, the stimulus flips a pin and raises the clear write at the same falling clock edge. Both are then seen by the one rising edge that follows. For the level case, the pin is held at its active level across the clear write, and the status bit is read back before the level is released.

A behavioural model in the bench tracks enables, status and edge history on every clock. It compares both interrupt lines and the read data at the current address each cycle.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;
  localparam int NUM_KINDS  = 6;
  localparam int WORD_W     = 32;
  localparam int BANK_IDX_W = 2;

  // kind indices; order matches the enable word layout
  localparam int K_RISE  = 0;
  localparam int K_FALL  = 1;
  localparam int K_HIGH  = 2;
  localparam int K_LOW   = 3;
  localparam int K_ARISE = 4;
  localparam int K_AFALL = 5;

  localparam int STS_BASE    = 'h40;
  localparam int EN_BASE     = 'h4C;
  localparam int KIND_STRIDE = 'h0C;

  typedef struct packed {
    logic [NUM_KINDS-1:0]  enWr;
    logic [NUM_KINDS-1:0]  enRd;
    logic                  stsW1c;
    logic                  stsRd;
    logic [BANK_IDX_W-1:0] bank;
  } strobe_t;
endpackage

// File: rtl/gpio_evt_ctrl.sv
module gpio_evt_ctrl
  import gpio_evt_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int ADDR_W    = 8
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] regAddr,
  output strobe_t           stb
);
  localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(4 * NUM_BANKS);

  logic [ADDR_W-1:0] diff;

  always_comb begin
    stb  = '0;
    diff = regAddr - ADDR_W'(STS_BASE);
    if (diff < SPAN && diff[1:0] == 2'b00) begin
      stb.stsRd  = 1'b1;
      stb.stsW1c = wrEn;
      stb.bank   = BANK_IDX_W'(diff >> 2);
    end
    for (int k = 0; k < NUM_KINDS; k++) begin
      diff = regAddr - ADDR_W'(EN_BASE + k * KIND_STRIDE);
      if (diff < SPAN && diff[1:0] == 2'b00) begin
        stb.enRd[k] = 1'b1;
        stb.enWr[k] = wrEn;
        stb.bank    = BANK_IDX_W'(diff >> 2);
      end
    end
  end
endmodule

// File: rtl/gpio_evt_dp.sv
module gpio_evt_dp
  import gpio_evt_pkg::*;
#(
  parameter int NUM_PINS  = 54,
  parameter int NUM_BANKS = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              stb,
  input  logic [WORD_W-1:0]    wrData,
  input  logic [NUM_PINS-1:0]  pinSync,
  input  logic [NUM_PINS-1:0]  pinRaw,
  output logic [WORD_W-1:0]    rdData,
  output logic [NUM_BANKS-1:0] irq
);
  localparam int TOT   = NUM_BANKS * WORD_W;
  localparam int SEL_W = $clog2(TOT);
  localparam logic [TOT-1:0] VALID = TOT'({NUM_PINS{1'b1}});

  logic [NUM_KINDS-1:0][TOT-1:0] enReg;
  logic [TOT-1:0] sts, syncPrev, rawPrev;
  logic [TOT-1:0] syncPad, rawPad, evt, clrVec;
  logic [SEL_W-1:0]  bankLo;
  logic [WORD_W-1:0] validWord;

  assign syncPad   = TOT'(pinSync);
  assign rawPad    = TOT'(pinRaw);
  assign bankLo    = SEL_W'(int'(stb.bank) * WORD_W);
  assign validWord = VALID[bankLo +: WORD_W];

  // event detection across all pins at once
  assign evt = VALID & ( (enReg[K_RISE]  &  syncPad & ~syncPrev)
                       | (enReg[K_FALL]  & ~syncPad &  syncPrev)
                       | (enReg[K_HIGH]  &  syncPad)
                       | (enReg[K_LOW]   & ~syncPad)
                       | (enReg[K_ARISE] &  rawPad  & ~rawPrev)
                       | (enReg[K_AFALL] & ~rawPad  &  rawPrev) );

  always_comb begin
    clrVec = '0;
    if (stb.stsW1c) clrVec[bankLo +: WORD_W] = wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg <= '0;
    end else begin
      for (int k = 0; k < NUM_KINDS; k++) begin
        if (stb.enWr[k]) enReg[k][bankLo +: WORD_W] <= wrData & validWord;
      end
    end
  end

  // set beats clear: the event term is ORed after the clear mask
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sts      <= '0;
      syncPrev <= '0;
      rawPrev  <= '0;
    end else begin
      sts      <= (sts & ~clrVec) | evt;
      syncPrev <= syncPad;
      rawPrev  <= rawPad;
    end
  end

  always_comb begin
    rdData = '0;
    if (stb.stsRd) rdData = sts[bankLo +: WORD_W];
    for (int k = 0; k < NUM_KINDS; k++) begin
      if (stb.enRd[k]) rdData = enReg[k][bankLo +: WORD_W];
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : gen_irq
    assign irq[b] = |sts[b*WORD_W +: WORD_W];
  end
endmodule

// File: rtl/gpio_evt_unit.sv
module gpio_evt_unit
  import gpio_evt_pkg::*;
#(
  parameter int NUM_PINS  = 54,
  parameter int ADDR_W    = 8,
  parameter int NUM_BANKS = (NUM_PINS + WORD_W - 1) / WORD_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_PINS-1:0]  pinSync,
  input  logic [NUM_PINS-1:0]  pinRaw,
  input  logic                 wrEn,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [WORD_W-1:0]    wrData,
  output logic [WORD_W-1:0]    rdData,
  output logic [NUM_BANKS-1:0] irq
);
  strobe_t stb;

  gpio_evt_ctrl #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) uCtrl (
    .wrEn(wrEn), .regAddr(regAddr), .stb(stb)
  );

  gpio_evt_dp #(.NUM_PINS(NUM_PINS), .NUM_BANKS(NUM_BANKS)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData),
    .pinSync(pinSync), .pinRaw(pinRaw), .rdData(rdData), .irq(irq)
  );
endmodule

// File: rtl/gpio_evt_chk.sv
module gpio_evt_chk
  import gpio_evt_pkg::*;
#(
  parameter int TOT = 64
) (
  input logic                          clk,
  input logic                          rstN,
  input strobe_t                       stb,
  input logic [WORD_W-1:0]             wrData,
  input logic [TOT-1:0]                sts,
  input logic [NUM_KINDS-1:0][TOT-1:0] enAll,
  input logic [TOT-1:0]                syncPad
);
  logic [TOT-1:0] lvlCond;
  assign lvlCond = (enAll[K_HIGH] & syncPad) | (enAll[K_LOW] & ~syncPad);

  // R8: without a clear carrying ones, no status bit drops
  a_r8_sticky_without_clear: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.stsW1c && wrData != '0) |=> ((sts & $past(sts)) == $past(sts)));

  // R6: a held level condition forces its bit set on the next clock
  a_r6_level_relatch: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((sts & $past(lvlCond)) == $past(lvlCond)));

  // R11: nothing enabled and nothing pending stays empty
  a_r11_idle_stays_clear: assert property (@(posedge clk) disable iff (!rstN)
    (enAll == '0 && sts == '0) |=> (sts == '0));

  // R8: an all-ones clear of bank 0 with no enables empties that bank
  a_r8_full_clear_empties: assert property (@(posedge clk) disable iff (!rstN)
    (stb.stsW1c && stb.bank == '0 && wrData == '1 && enAll == '0)
      |=> (sts[WORD_W-1:0] == '0));
endmodule

bind gpio_evt_dp gpio_evt_chk #(.TOT(TOT)) uChk (
  .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData),
  .sts(sts), .enAll(enReg), .syncPad(syncPad)
);

// File: tb/gpio_evt_unit_test.sv
module gpio_evt_unit_test;
  localparam int NP = 54;
  localparam bit [63:0] VALID64 = (64'd1 << NP) - 64'd1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NP-1:0] pinSync = '0;
  logic [NP-1:0] pinRaw  = '0;
  logic wrEn = 1'b0;
  logic [7:0] regAddr = 8'h00;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [1:0] irq;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  gpio_evt_unit uut (
    .clk(clk), .rstN(rstN), .pinSync(pinSync), .pinRaw(pinRaw),
    .wrEn(wrEn), .regAddr(regAddr), .wrData(wrData), .rdData(rdData), .irq(irq)
  );

  // behavioural reference model
  bit [63:0] mEn [6];
  bit [63:0] mSts, mSyncPrev, mRawPrev;

  function automatic bit [31:0] modelRead(bit [7:0] a);
    if (a == 8'h40) return mSts[31:0];
    if (a == 8'h44) return mSts[63:32];
    for (int k = 0; k < 6; k++) begin
      if (int'(a) == 'h4C + 12 * k)     return mEn[k][31:0];
      if (int'(a) == 'h4C + 12 * k + 4) return mEn[k][63:32];
    end
    return 32'h0;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < 6; k++) mEn[k] = '0;
      mSts = '0; mSyncPrev = '0; mRawPrev = '0;
    end else begin
      bit [63:0] s, r, ev, clr;
      s = 64'(pinSync);
      r = 64'(pinRaw);
      ev = VALID64 & ((mEn[0] & s & ~mSyncPrev) | (mEn[1] & ~s & mSyncPrev) |
                      (mEn[2] & s) | (mEn[3] & ~s) |
                      (mEn[4] & r & ~mRawPrev) | (mEn[5] & ~r & mRawPrev));
      clr = '0;
      if (wrEn) begin
        if (regAddr == 8'h40) clr[31:0]  = wrData;
        if (regAddr == 8'h44) clr[63:32] = wrData;
        for (int k = 0; k < 6; k++) begin
          if (int'(regAddr) == 'h4C + 12 * k)     mEn[k][31:0]  = wrData;
          if (int'(regAddr) == 'h4C + 12 * k + 4) mEn[k][63:32] = wrData & VALID64[63:32];
        end
      end
      mSts = (mSts & ~clr) | ev;
      mSyncPrev = s;
      mRawPrev = r;
    end
  end

  // per-cycle comparison against the model
  always @(posedge clk) begin
    #5;
    if (rstN) begin
      checks++;
      if (irq !== {|mSts[63:32], |mSts[31:0]}) begin
        failures++;
        $display("FAIL R10 irq actual %b expected %b", irq, {|mSts[63:32], |mSts[31:0]});
      end
      checks++;
      if (rdData !== modelRead(regAddr)) begin
        failures++;
        $display("FAIL R2 read @%h actual %h expected %h", regAddr, rdData, modelRead(regAddr));
      end
    end
  end

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(bit [7:0] a, bit [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; regAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic chkReg(bit [7:0] a, bit [31:0] exp, string tag);
    regAddr = a;
    #1;
    checks++;
    if (rdData !== exp) begin
      failures++;
      $display("FAIL %s reg %h actual %h expected %h", tag, a, rdData, exp);
    end
  endtask

  task automatic chkIrq(bit [1:0] exp, string tag);
    #1;
    checks++;
    if (irq !== exp) begin
      failures++;
      $display("FAIL %s irq actual %b expected %b", tag, irq, exp);
    end
  endtask

  initial begin
    #(20 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    step(3);
    rstN = 1'b1;
    step();
    // R1 reset state
    chkReg(8'h40, 0, "R1"); chkReg(8'h44, 0, "R1");
    chkReg(8'h4C, 0, "R1"); chkReg(8'h88, 0, "R1");
    chkIrq(2'b00, "R1");
    // R2 enable words and masking
    wr(8'h50, 32'hFFFF_FFFF); chkReg(8'h50, 32'h003F_FFFF, "R2");
    wr(8'h7C, 32'hA5A5_A5A5); chkReg(8'h7C, 32'hA5A5_A5A5, "R2");
    wr(8'h50, 0); wr(8'h7C, 0); chkReg(8'h50, 0, "R2");
    // R3 sync rising, R8 clear semantics
    wr(8'h4C, 32'h8);
    pinSync[3] = 1'b1; step();
    chkReg(8'h40, 32'h8, "R3"); chkIrq(2'b01, "R10");
    wr(8'h40, 0); chkReg(8'h40, 32'h8, "R8");
    wr(8'h40, 32'h8); chkReg(8'h40, 0, "R8"); chkIrq(2'b00, "R8");
    pinSync[3] = 1'b0; step(); chkReg(8'h40, 0, "R11");
    // R4 sync falling on pin 40
    wr(8'h5C, 32'h100);
    pinSync[40] = 1'b1; step(); chkReg(8'h44, 0, "R4");
    pinSync[40] = 1'b0; step(); chkReg(8'h44, 32'h100, "R4");
    chkIrq(2'b10, "R10");
    wr(8'h44, 32'h100); chkReg(8'h44, 0, "R4");
    // R5 both edges on pin 5
    wr(8'h4C, 32'h20); wr(8'h58, 32'h20);
    pinSync[5] = 1'b1; step(); chkReg(8'h40, 32'h20, "R5");
    wr(8'h40, 32'h20); chkReg(8'h40, 0, "R5");
    pinSync[5] = 1'b0; step(); chkReg(8'h40, 32'h20, "R5");
    wr(8'h40, 32'h20);
    // R6 high level pin 7
    wr(8'h64, 32'h80);
    pinSync[7] = 1'b1; step(); chkReg(8'h40, 32'h80, "R6");
    wr(8'h40, 32'h80); chkReg(8'h40, 32'h80, "R6");
    pinSync[7] = 1'b0; step();
    wr(8'h40, 32'h80); chkReg(8'h40, 0, "R6");
    // R6 low level pin 50
    wr(8'h74, 32'h4_0000); step();
    chkReg(8'h44, 32'h4_0000, "R6"); chkIrq(2'b10, "R6");
    pinSync[50] = 1'b1; step();
    wr(8'h44, 32'h4_0000); chkReg(8'h44, 0, "R6");
    // R7 raw rising pin 10, raw falling pin 33
    wr(8'h7C, 32'h400);
    pinRaw[10] = 1'b1; step(); chkReg(8'h40, 32'h400, "R7");
    wr(8'h40, 32'h400); chkReg(8'h40, 0, "R7");
    pinRaw[10] = 1'b0; step(); chkReg(8'h40, 0, "R7");
    wr(8'h8C, 32'h2);
    pinRaw[33] = 1'b1; step(); chkReg(8'h44, 0, "R7");
    pinRaw[33] = 1'b0; step(); chkReg(8'h44, 32'h2, "R7");
    wr(8'h44, 32'h2);
    // R9 event and clear in the same cycle
    pinSync[5] = 1'b1; step(); chkReg(8'h40, 32'h20, "R9");
    pinSync[5] = 1'b0;
    wrEn = 1'b1; regAddr = 8'h40; wrData = 32'h20;
    @(negedge clk);
    wrEn = 1'b0;
    chkReg(8'h40, 32'h20, "R9");
    wr(8'h40, 32'h20); chkReg(8'h40, 0, "R9");
    // R10 bank isolation
    pinSync[5] = 1'b1; pinSync[40] = 1'b1; step();
    pinSync[40] = 1'b0; step();
    chkIrq(2'b11, "R10");
    wr(8'h40, 32'h20); chkIrq(2'b10, "R10");
    chkReg(8'h44, 32'h100, "R10");
    wr(8'h44, 32'h100); chkIrq(2'b00, "R10");
    // R11 pin 20 without enables
    for (int i = 0; i < 4; i++) begin
      pinSync[20] = ~pinSync[20]; pinRaw[20] = ~pinRaw[20]; step();
    end
    chkReg(8'h40, 0, "R11"); chkIrq(2'b00, "R11");
    step(2);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule